// File: doc/BRIEF.md
# Firmware Image SysEx Packet Decoder

This block sits on a byte stream of MIDI System Exclusive messages that carry a firmware image. It follows each message from its opening F0 to its closing F7 and checks the header, the length, the image name and the checksum. It then turns the 7-bit payload back into 8-bit firmware bytes. Each decoded byte leaves on a valid/ready stream together with the block number of the packet it came from. One-cycle status pulses report each packet as good, as failing its checksum, or as badly framed.

Two further message kinds are recognised. An erase message raises an event and clears the running image sum. A final-checksum message raises an event, and a match flag beside that event tells whether the received byte agrees with the sum of every firmware byte decoded since the last erase or reset. The payload places the byte that carries the high bits after each run of seven data bytes. The block therefore holds up to seven low halves until that byte arrives, then plays them out while it stalls the input.

Top module: `sysex_fw_decoder`

## Requirements
- R1: After reset in_ready is 1, out_valid is 0 and every status pulse and csum_match are 0.
- R2: A data message is F0 43 7D 40, two length bytes, the ASCII text DTA1MAIN, two block-number bytes, 7F 7F, the payload, one checksum byte and F7. For every payload group of seven data bytes followed by one high-bit byte, seven bytes leave on out_data in arrival order. Data byte i (0-based) takes its low 7 bits from its own payload byte and bit 7 from bit 6-i of the high-bit byte.
- R3: The length field and the block number are each decoded as first*128 + second. The length counts the bytes from the D of DTA1MAIN up to the last payload byte. out_block carries the decoded block number with every decoded byte.
- R4: The last byte of the length-counted region always acts as the high-bit byte of a final group. If that group holds k < 7 data bytes, exactly k bytes are emitted, using high bits 6 down to 7-k.
- R5: The checksum byte must equal the low 7 bits of the two's complement negation of the sum of the length-counted bytes. On the accepted F7 that closes such a message, pkt_good pulses for one cycle in the next cycle. If the checksum does not match, pkt_bad_sum pulses instead.
- R6: Inside a recognised message, any of the following raises a one-cycle pkt_bad_frame pulse and makes the block ignore bytes up to the next F7 or F0: a byte with bit 7 set where data is expected, a wrong fixed byte, a wrong text character, a length below 12, or a missing F7. Decoded bytes not yet released before the error still come out; no further bytes are emitted.
- R7: An F0 that arrives inside a message in progress raises pkt_bad_frame and starts a new message at once.
- R8: F0 43 7D 30, then DTA1ERASE, then 02, then F7 pulses erase_evt and clears the running image sum.
- R9: F0 43 7D 70, then DTA1CSUM, then one byte, then F7 pulses csum_evt. In the same cycle csum_match is 1 exactly when that byte equals the low 7 bits of the negated sum of all bytes emitted since the last erase or reset.
- R10: While out_valid is 1 and out_ready is 0, out_data and out_block hold. in_ready stays 0 whenever decoded bytes are pending, so no input byte is lost.
- R11: Bytes outside any message, and messages whose third byte after F0 is a 7-bit value other than 40, 30 or 70, produce no output and no status pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | MIDI byte |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Decoded firmware byte present |
| out_data | output | 8 | Decoded firmware byte |
| out_block | output | 14 | Block number of the current packet |
| out_ready | input | 1 | Sink takes the decoded byte |
| pkt_good | output | 1 | Data packet closed with a correct checksum |
| pkt_bad_sum | output | 1 | Data packet closed with a wrong checksum |
| pkt_bad_frame | output | 1 | Framing error detected |
| erase_evt | output | 1 | Erase message received |
| csum_evt | output | 1 | Final-checksum message received |
| csum_match | output | 1 | Final checksum agrees, valid with csum_evt |

## Verification
A group index that drifts by one shows up within eight payload bytes, as decoded bytes with the wrong top bit or a wrong number of bytes per group. A fault in the packet sum or the image sum stays hidden until the closing F7 or the final-checksum message, where the wrong pulse or flag appears one cycle later. The tests therefore mix full and partial groups, data with high bits set, backpressure, and corrupted frames and checksums, and they follow every erase with a final-checksum check.

// File: rtl/sysex_fw_decoder.sv
module sysex_fw_decoder #(
  parameter logic [7:0] ERASE_REGION = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic [13:0] out_block,
  input  logic        out_ready,
  output logic        pkt_good,
  output logic        pkt_bad_sum,
  output logic        pkt_bad_frame,
  output logic        erase_evt,
  output logic        csum_evt,
  output logic        csum_match
);

  localparam logic [7:0]  CMD_DATA  = 8'h40;
  localparam logic [7:0]  CMD_ERASE = 8'h30;
  localparam logic [7:0]  CMD_CSUM  = 8'h70;
  localparam logic [63:0] NM_DATA   = "DTA1MAIN";
  localparam logic [71:0] NM_ERASE  = "DTA1ERASE";
  localparam logic [63:0] NM_CSUM   = "DTA1CSUM";

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_DATA, S_SUM, S_TAIL, S_SKIP} st_t;

  st_t         st;
  logic [3:0]  pos;
  logic [7:0]  cmd;
  logic [6:0]  len_hi;
  logic [13:0] len, ridx;
  logic [2:0]  grp, e_pos, e_end;
  logic [6:0]  grp_buf [8];
  logic [7:0]  hib;
  logic [6:0]  psum, isum, cbyte;
  logic        sum_ok;
  logic        good_q, bsum_q, bframe_q, erase_q, csum_q, match_q;

  wire        acc      = in_valid && in_ready;
  wire  [7:0] b        = in_data;
  wire        hi       = in_data[7];
  wire        emitting = e_pos != e_end;
  wire  [3:0] pos_m3   = pos - 4'd3;
  wire  [7:0] ch_d     = 8'(NM_DATA  >> {3'd7 - ridx[2:0], 3'b000});
  wire  [7:0] ch_e     = 8'(NM_ERASE >> {4'd8 - pos_m3, 3'b000});
  wire  [7:0] ch_c     = 8'(NM_CSUM  >> {3'd7 - pos_m3[2:0], 3'b000});
  wire        last_rg  = ridx == len - 14'd1;

  assign in_ready      = !emitting;
  assign out_valid     = emitting;
  assign out_data      = {hib[3'd6 - e_pos], grp_buf[e_pos]};
  assign pkt_good      = good_q;
  assign pkt_bad_sum   = bsum_q;
  assign pkt_bad_frame = bframe_q;
  assign erase_evt     = erase_q;
  assign csum_evt      = csum_q;
  assign csum_match    = match_q;

  always_ff @(posedge clk) begin
    if (acc && st == S_DATA && !hi && ridx >= 14'd12 && !(last_rg || grp == 3'd7))
      grp_buf[grp] <= b[6:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pos <= '0; cmd <= '0; len_hi <= '0; len <= '0; ridx <= '0;
      grp <= '0; e_pos <= '0; e_end <= '0; hib <= '0; out_block <= '0;
      psum <= '0; isum <= '0; cbyte <= '0; sum_ok <= 1'b0;
      good_q <= 1'b0; bsum_q <= 1'b0; bframe_q <= 1'b0;
      erase_q <= 1'b0; csum_q <= 1'b0; match_q <= 1'b0;
    end else begin
      good_q <= 1'b0; bsum_q <= 1'b0; bframe_q <= 1'b0;
      erase_q <= 1'b0; csum_q <= 1'b0; match_q <= 1'b0;
      if (emitting && out_ready) begin
        e_pos <= e_pos + 3'd1;
        isum  <= isum + out_data[6:0];
      end
      if (acc) begin
        if (b == 8'hF0) begin
          if (st != S_IDLE && st != S_SKIP) bframe_q <= 1'b1;
          st <= S_HEAD; pos <= '0; psum <= '0;
        end else begin
          case (st)
            S_SKIP: if (b == 8'hF7) st <= S_IDLE;
            S_HEAD: begin
              pos <= pos + 4'd1;
              if (pos == 4'd0) begin
                if (b != 8'h43) begin bframe_q <= 1'b1; st <= S_SKIP; end
              end else if (pos == 4'd1) begin
                if (b != 8'h7D) begin bframe_q <= 1'b1; st <= S_SKIP; end
              end else if (pos == 4'd2) begin
                if (b == CMD_DATA || b == CMD_ERASE || b == CMD_CSUM) cmd <= b;
                else if (hi) begin bframe_q <= 1'b1; st <= S_SKIP; end
                else st <= S_SKIP;
              end else if (cmd == CMD_DATA) begin
                if (hi) begin bframe_q <= 1'b1; st <= S_SKIP; end
                else if (pos == 4'd3) len_hi <= b[6:0];
                else begin
                  len <= {len_hi, b[6:0]}; ridx <= '0; grp <= '0;
                  if ({len_hi, b[6:0]} < 14'd12) begin bframe_q <= 1'b1; st <= S_SKIP; end
                  else st <= S_DATA;
                end
              end else if (cmd == CMD_ERASE) begin
                if (pos == 4'd13) begin
                  if (b == 8'hF7) begin erase_q <= 1'b1; isum <= '0; st <= S_IDLE; end
                  else begin bframe_q <= 1'b1; st <= S_SKIP; end
                end else if (pos == 4'd12) begin
                  if (b != ERASE_REGION) begin bframe_q <= 1'b1; st <= S_SKIP; end
                end else if (b != ch_e) begin bframe_q <= 1'b1; st <= S_SKIP; end
              end else begin
                if (pos == 4'd12) begin
                  if (b == 8'hF7) begin
                    csum_q <= 1'b1; match_q <= cbyte == 7'(7'd0 - isum); st <= S_IDLE;
                  end else begin bframe_q <= 1'b1; st <= S_SKIP; end
                end else if (pos == 4'd11) begin
                  if (hi) begin bframe_q <= 1'b1; st <= S_SKIP; end
                  else cbyte <= b[6:0];
                end else if (b != ch_c) begin bframe_q <= 1'b1; st <= S_SKIP; end
              end
            end
            S_DATA: begin
              if (hi) begin bframe_q <= 1'b1; st <= S_SKIP; end
              else begin
                psum <= psum + b[6:0];
                ridx <= ridx + 14'd1;
                if (ridx >= 14'd12) begin
                  if (last_rg || grp == 3'd7) begin
                    hib <= {1'b0, b[6:0]}; e_pos <= '0; e_end <= grp; grp <= '0;
                  end else grp <= grp + 3'd1;
                end else if (ridx == 14'd8 || ridx == 14'd9)
                  out_block <= {out_block[6:0], b[6:0]};
                if (last_rg) st <= S_SUM;
                if (ridx < 14'd8 && b != ch_d) begin bframe_q <= 1'b1; st <= S_SKIP; end
                if ((ridx == 14'd10 || ridx == 14'd11) && b != 8'h7F) begin
                  bframe_q <= 1'b1; st <= S_SKIP;
                end
              end
            end
            S_SUM: begin
              if (hi) begin bframe_q <= 1'b1; st <= S_SKIP; end
              else begin sum_ok <= b[6:0] == 7'(7'd0 - psum); st <= S_TAIL; end
            end
            S_TAIL: begin
              if (b == 8'hF7) begin good_q <= sum_ok; bsum_q <= !sum_ok; st <= S_IDLE; end
              else begin bframe_q <= 1'b1; st <= S_SKIP; end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_block)); // R10
  AST_NO_INPUT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_good, pkt_bad_sum, pkt_bad_frame, erase_evt, csum_evt})); // R6
  AST_CLOSE_ON_F7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_good || pkt_bad_sum || erase_evt || csum_evt |-> $past(in_valid && in_ready && in_data == 8'hF7)); // R5
  AST_MATCH_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    csum_match |-> csum_evt); // R9
  AST_OUT_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R2

endmodule

// File: tb/sysex_fw_decoder_test.sv
module sysex_fw_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, pkt_good, pkt_bad_sum, pkt_bad_frame, erase_evt, csum_evt, csum_match;
  logic [7:0] out_data;
  logic [13:0] out_block;

  sysex_fw_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_block(out_block), .out_ready(out_ready),
    .pkt_good(pkt_good), .pkt_bad_sum(pkt_bad_sum), .pkt_bad_frame(pkt_bad_frame),
    .erase_evt(erase_evt), .csum_evt(csum_evt), .csum_match(csum_match));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] msg [0:511];
  int mlen;
  logic [7:0] fw [0:63];
  logic [7:0] got [0:127];
  logic [13:0] gblk [0:127];
  int ngot = 0, n_good = 0, n_bsum = 0, n_bframe = 0, n_erase = 0, n_csum = 0, last_match = 0;
  bit stall = 0;
  int cyc = 0;

  always @(negedge clk) begin
    logic r;
    cyc++;
    r = stall ? (cyc % 3 == 1) : 1'b1;
    out_ready = r;
    if (out_valid && r && ngot < 128) begin got[ngot] = out_data; gblk[ngot] = out_block; ngot++; end
    if (pkt_good) n_good++;
    if (pkt_bad_sum) n_bsum++;
    if (pkt_bad_frame) n_bframe++;
    if (erase_evt) n_erase++;
    if (csum_evt) begin n_csum++; last_match = int'(csum_match); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic clr();
    ngot = 0; n_good = 0; n_bsum = 0; n_bframe = 0; n_erase = 0; n_csum = 0; last_match = 0;
  endtask

  task automatic push(input logic [7:0] v); msg[mlen] = v; mlen++; endtask
  task automatic push_str(input string s);
    for (int i = 0; i < s.len(); i++) push(s[i]);
  endtask

  task automatic send_byte(input logic [7:0] v);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_msg(input int upto);
    for (int i = 0; i < upto; i++) send_byte(msg[i]);
  endtask

  task automatic drain(); repeat (40) @(negedge clk); endtask

  task automatic make_fw(input int n, input int seed);
    for (int i = 0; i < n; i++) fw[i] = 8'((i * 73 + seed * 29 + 5) & 255);
  endtask

  // corrupt: 0 none, 1 wrong checksum, 2 wrong name character
  task automatic build_pkt(input int blk, input int n, input int corrupt);
    int len, sum;
    logic [7:0] cs;
    mlen = 0;
    push(8'hF0); push(8'h43); push(8'h7D); push(8'h40); push(8'h00); push(8'h00);
    push_str("DTA1MAIN");
    push(8'((blk >> 7) & 127)); push(8'(blk & 127)); push(8'h7F); push(8'h7F);
    for (int g = 0; g < n; g += 7) begin
      int k;
      logic [7:0] col;
      k = (n - g < 7) ? n - g : 7;
      col = 8'h00;
      for (int i = 0; i < k; i++) begin
        push({1'b0, fw[g + i][6:0]});
        col[6 - i] = fw[g + i][7];
      end
      push(col);
    end
    len = mlen - 6;
    msg[4] = 8'((len >> 7) & 127); msg[5] = 8'(len & 127);
    sum = 0;
    for (int i = 6; i < mlen; i++) sum += msg[i];
    cs = 8'((-sum) & 127);
    if (corrupt == 1) cs = cs ^ 8'h01;
    push(cs); push(8'hF7);
    if (corrupt == 2) msg[7] = "X";
  endtask

  task automatic build_erase();
    mlen = 0; push(8'hF0); push(8'h43); push(8'h7D); push(8'h30);
    push_str("DTA1ERASE"); push(8'h02); push(8'hF7);
  endtask

  task automatic build_csum(input logic [7:0] cs);
    mlen = 0; push(8'hF0); push(8'h43); push(8'h7D); push(8'h70);
    push_str("DTA1CSUM"); push(cs); push(8'hF7);
  endtask

  task automatic check_bytes(input int n, input int blk, input string req);
    chk(ngot == n, req, ngot, n);
    for (int i = 0; i < n && i < ngot; i++) begin
      chk(got[i] == fw[i], req, got[i], fw[i]);
      chk(gblk[i] == 14'(blk), req, gblk[i], blk);
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk({pkt_good, pkt_bad_sum, pkt_bad_frame, erase_evt, csum_evt, csum_match} == 6'd0,
        "R1 pulses", {pkt_good, pkt_bad_sum, pkt_bad_frame, erase_evt, csum_evt, csum_match}, 0);
  endtask

  task automatic t_full();
    clr(); make_fw(14, 1); build_pkt(300, 14, 0); send_msg(mlen); drain();
    check_bytes(14, 300, "R2 R3 full groups");
    chk(n_good == 1, "R5 good", n_good, 1);
    chk(n_bsum + n_bframe == 0, "R5 no error", n_bsum + n_bframe, 0);
  endtask

  task automatic t_partial();
    clr(); make_fw(10, 2); fw[7] = 8'hFF; fw[9] = 8'h80;
    build_pkt(5, 10, 0); send_msg(mlen); drain();
    check_bytes(10, 5, "R4 partial group");
    chk(n_good == 1, "R4 good", n_good, 1);
  endtask

  task automatic t_stall();
    clr(); stall = 1; make_fw(21, 3); build_pkt(16383, 21, 0); send_msg(mlen); drain();
    stall = 0;
    check_bytes(21, 16383, "R10 backpressure");
    chk(n_good == 1, "R10 good", n_good, 1);
  endtask

  task automatic t_badsum();
    clr(); make_fw(7, 4); build_pkt(1, 7, 1); send_msg(mlen); drain();
    chk(n_bsum == 1, "R5 bad checksum", n_bsum, 1);
    chk(n_good == 0, "R5 not good", n_good, 0);
  endtask

  task automatic t_badframe();
    clr(); make_fw(7, 5); build_pkt(2, 7, 2); send_msg(mlen); drain();
    chk(n_bframe == 1, "R6 bad name", n_bframe, 1);
    chk(ngot == 0 && n_good == 0, "R6 nothing out", ngot + n_good, 0);
    clr(); build_pkt(2, 7, 0); msg[18] = 8'h85; send_msg(mlen); drain();
    chk(n_bframe == 1, "R6 high bit in payload", n_bframe, 1);
    chk(ngot == 0 && n_good + n_bsum == 0, "R6 payload dropped", ngot + n_good + n_bsum, 0);
  endtask

  task automatic t_abort();
    clr(); make_fw(9, 6); build_pkt(77, 9, 0); send_msg(9); send_msg(mlen); drain();
    chk(n_bframe == 1, "R7 abort flagged", n_bframe, 1);
    chk(n_good == 1, "R7 restart good", n_good, 1);
    check_bytes(9, 77, "R7 restart data");
  endtask

  task automatic t_image();
    int sum;
    clr(); build_erase(); send_msg(mlen); drain();
    chk(n_erase == 1, "R8 erase event", n_erase, 1);
    make_fw(14, 7); build_pkt(3, 14, 0); send_msg(mlen); drain();
    sum = 0;
    for (int i = 0; i < 14; i++) sum += fw[i];
    clr(); build_csum(8'((-sum) & 127)); send_msg(mlen); drain();
    chk(n_csum == 1, "R9 csum event", n_csum, 1);
    chk(last_match == 1, "R9 csum match", last_match, 1);
    clr(); build_csum(8'(((-sum) + 1) & 127)); send_msg(mlen); drain();
    chk(n_csum == 1 && last_match == 0, "R9 csum mismatch", last_match, 0);
    clr(); build_erase(); send_msg(mlen); build_csum(8'h00); send_msg(mlen); drain();
    chk(n_erase == 1 && last_match == 1, "R8 erase clears sum", last_match, 1);
  endtask

  task automatic t_ignore();
    clr();
    send_byte(8'h12); send_byte(8'h7F); send_byte(8'hF7);
    mlen = 0; push(8'hF0); push(8'h43); push(8'h7D); push(8'h11); push(8'h01); push(8'h02); push(8'hF7);
    send_msg(mlen); drain();
    chk(ngot + n_good + n_bsum + n_bframe + n_erase + n_csum == 0, "R11 ignored",
        ngot + n_good + n_bsum + n_bframe + n_erase + n_csum, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_partial();
    t_stall();
    t_badsum();
    t_badframe();
    t_abort();
    t_image();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule